// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead-Time Insertion

This block produces the four gate commands of one full bridge: a high-side and a low-side switch on each of two legs. An enable and two direction bits select one of five bridge states. A chop request from an external current regulator can also modify the state. Each leg follows its own direction bit. When the bit is high the leg connects its output to supply. When the bit is low the leg connects its output to ground. When enable is low the leg leaves its output floating.

While a chop request is active, every leg that would sit at ground is released. Load current then circulates through the two upper switches. Once the dead time has passed, the released leg's high-side switch closes so that the recirculation runs through a conducting switch rather than a body diode (slow decay with synchronous rectification).

Every gate output comes straight from a flop. Whenever a leg moves from one conducting switch to the other, or turns a switch on after any turn-off, a programmable number of clock cycles of all-off time is inserted first. Switching the direction bits mid-run is handled like any other leg change.

Top module: `hb_gate_ctl`

## Requirements
- R1: While `en_i` is low at a clock edge, all four gate outputs are low after that edge.
- R2: With `en_i` high and no chop, a leg whose direction bit is high (`in1_i` for leg 1, `in2_i` for leg 2) ends with its high-side gate on and low-side gate off, and a leg whose bit is low ends with its low-side gate on. So `in1_i`=1, `in2_i`=0 gives forward (hs1, ls2), and the opposite combination gives reverse (ls1, hs2).
- R3: With `en_i` high, no chop and both direction bits low, both low-side gates end up on (lower-path brake).
- R4: With `en_i` high and both direction bits high, both high-side gates end up on (upper-path brake), whether or not chop is requested.
- R5: Gate outputs are flops and change one clock edge after the inputs are sampled. Reset holds all four low. The high-side and low-side gate of one leg are never high in the same cycle.
- R6: A gate turns on only after its leg has had both gates low for `DEAD_CYC` consecutive cycles. When the leg target holds steady, the all-off gap is exactly `DEAD_CYC` cycles. After reset, or once a leg has been off for `DEAD_CYC` cycles or longer, a turn-on happens on the next edge.
- R7: While `chop_i` is high, every low-side gate is low one edge later. A leg that was at ground turns its high-side gate on after the dead time (synchronous rectification).
- R8: When `chop_i` falls, the released leg's high-side gate turns off, and its low-side gate returns only after the dead time.
- R9: A change of the leg target during a running dead time does not shorten it. This covers re-enabling after a short disable and returning to the previous direction. The new turn-on still waits for the full `DEAD_CYC` cycles counted from the turn-off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Bridge enable; low floats both outputs |
| in1_i | input | 1 | Direction bit of leg 1 |
| in2_i | input | 1 | Direction bit of leg 2 |
| chop_i | input | 1 | Chop (off-time) request from the current regulator |
| hs1_o | output | 1 | Leg 1 high-side gate |
| ls1_o | output | 1 | Leg 1 low-side gate |
| hs2_o | output | 1 | Leg 2 high-side gate |
| ls2_o | output | 1 | Leg 2 low-side gate |

## Verification
The bound checker watches every cycle for the safety properties:
- no leg ever has both gates on;
- no gate rises before its leg has been all-off for the dead time;
- a low enable clears all gates on the next edge;
- a chop request clears the low-side gates on the next edge.

Which state the bridge settles in for each input combination, and the exact length of each all-off gap, are shown only by the bench's scenarios. The same holds for dead times that survive a target change part-way through, and for immediate turn-on after a long idle time.

// File: rtl/hb_gate_pkg.sv
`timescale 1ns/1ps
package hb_gate_pkg;

  // Leg drive state; bit 0 is the high-side gate, bit 1 the low-side gate,
  // so the state register can drive the gate pins directly.
  typedef enum logic [1:0] {
    LEG_OFF  = 2'b00,
    LEG_HIGH = 2'b01,
    LEG_LOW  = 2'b10
  } leg_e;

  localparam int NUM_LEGS = 2;

endpackage

// File: rtl/hb_rst_sync.sv
`timescale 1ns/1ps
module hb_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/hb_mode_decode.sv
`timescale 1ns/1ps
module hb_mode_decode
  import hb_gate_pkg::*;
#(
  parameter int LEGS = NUM_LEGS
) (
  input  logic            en_i,
  input  logic [LEGS-1:0] dir_i,
  input  logic            chop_i,
  output leg_e            tgt_o [LEGS]
);

  // Each leg follows its own direction bit; a chop request lifts every
  // grounded leg so the load current circulates through the upper half.
  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    always_comb begin
      if (!en_i) begin
        tgt_o[g] = LEG_OFF;
      end else if (dir_i[g] || chop_i) begin
        tgt_o[g] = LEG_HIGH;
      end else begin
        tgt_o[g] = LEG_LOW;
      end
    end
  end

endmodule

// File: rtl/hb_leg_ctl.sv
`timescale 1ns/1ps
module hb_leg_ctl
  import hb_gate_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  leg_e tgt_i,
  output logic hs_o,
  output logic ls_o
);

  localparam int CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(DEAD_CYC - 1);

  leg_e          cur_q, cur_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          cur_en;

  // Next state: any change first drops the leg to off and arms the counter;
  // a turn-on from off is only allowed once the counter has drained.
  always_comb begin
    cur_d  = cur_q;
    cnt_d  = cnt_q;
    cnt_en = (cnt_q != '0);
    cur_en = 1'b0;
    if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
    if (tgt_i != cur_q) begin
      if (cur_q != LEG_OFF) begin
        cur_d  = LEG_OFF;
        cnt_d  = RELOAD;
        cnt_en = 1'b1;
        cur_en = 1'b1;
      end else if (cnt_q == '0) begin
        cur_d  = tgt_i;
        cur_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= LEG_OFF;
      cnt_q <= '0;
    end else begin
      if (cur_en) cur_q <= cur_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign hs_o = cur_q[0];
  assign ls_o = cur_q[1];

endmodule

// File: rtl/hb_gate_ctl.sv
`timescale 1ns/1ps
module hb_gate_ctl
  import hb_gate_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic in1_i,
  input  logic in2_i,
  input  logic chop_i,
  output logic hs1_o,
  output logic ls1_o,
  output logic hs2_o,
  output logic ls2_o
);

  logic                rst_sync_n;
  logic [NUM_LEGS-1:0] dir;
  logic [NUM_LEGS-1:0] hs;
  logic [NUM_LEGS-1:0] ls;
  leg_e                tgt [NUM_LEGS];

  assign dir = {in2_i, in1_i};

  hb_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  hb_mode_decode #(.LEGS(NUM_LEGS)) u_dec (
    .en_i   (en_i),
    .dir_i  (dir),
    .chop_i (chop_i),
    .tgt_o  (tgt)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    hb_leg_ctl #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .tgt_i (tgt[g]),
      .hs_o  (hs[g]),
      .ls_o  (ls[g])
    );
  end

  assign hs1_o = hs[0];
  assign ls1_o = ls[0];
  assign hs2_o = hs[1];
  assign ls2_o = ls[1];

endmodule

// File: rtl/hb_gate_ctl_chk.sv
`timescale 1ns/1ps
module hb_gate_ctl_chk #(
  parameter int DEAD_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic chop_i,
  input logic hs1_o,
  input logic ls1_o,
  input logic hs2_o,
  input logic ls2_o
);

  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] SAT = CW'(DEAD_CYC);

  // Consecutive all-off cycles per leg, saturating at the dead time.
  logic [CW-1:0] off_run1, off_run2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_run1 <= SAT;
      off_run2 <= SAT;
    end else begin
      if (hs1_o || ls1_o)   off_run1 <= '0;
      else if (off_run1 < SAT) off_run1 <= off_run1 + 1'b1;
      if (hs2_o || ls2_o)   off_run2 <= '0;
      else if (off_run2 < SAT) off_run2 <= off_run2 + 1'b1;
    end
  end

  assert_no_shoot_leg1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs1_o && ls1_o));
  assert_no_shoot_leg2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs2_o && ls2_o));

  assert_dead_hs1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs1_o) |-> (off_run1 >= SAT));
  assert_dead_ls1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls1_o) |-> (off_run1 >= SAT));
  assert_dead_hs2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs2_o) |-> (off_run2 >= SAT));
  assert_dead_ls2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls2_o) |-> (off_run2 >= SAT));

  assert_disable_float_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!hs1_o && !ls1_o && !hs2_o && !ls2_o));

  assert_chop_low_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chop_i |=> (!ls1_o && !ls2_o));

endmodule

bind hb_gate_ctl hb_gate_ctl_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en_i   (en_i),
  .chop_i (chop_i),
  .hs1_o  (hs1_o),
  .ls1_o  (ls1_o),
  .hs2_o  (hs2_o),
  .ls2_o  (ls2_o)
);

// File: tb/hb_gate_ctl_test.sv
`timescale 1ns/1ps
module hb_gate_ctl_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEAD       = 4;

  logic clk, rst_n, en, in1, in2, chop;
  logic hs1, ls1, hs2, ls2;

  logic [3:0] exp_q [$];
  string      tag_q [$];
  int         n_chk, n_bad;

  hb_gate_ctl #(.DEAD_CYC(DEAD)) uut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .in1_i(in1), .in2_i(in2),
    .chop_i(chop), .hs1_o(hs1), .ls1_o(ls1), .hs2_o(hs2), .ls2_o(ls2)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Vector order {hs1, ls1, hs2, ls2}
  function automatic logic [3:0] gates();
    return {hs1, ls1, hs2, ls2};
  endfunction

  task automatic compare(input logic [3:0] ex, input string tag);
    n_chk++;
    if (gates() !== ex) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, gates(), ex, $time);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the result expected after the next edge.
  task automatic drv(input logic e, a, b, c, input logic [3:0] ex, input string tag);
    @(negedge clk);
    en = e; in1 = a; in2 = b; chop = c;
    exp_q.push_back(ex);
    tag_q.push_back(tag);
  endtask

  task automatic drvn(input int n, input logic e, a, b, c, input logic [3:0] ex,
                      input string tag);
    for (int i = 0; i < n; i++) drv(e, a, b, c, ex, tag);
  endtask

  // Monitor: one queued expectation per clock edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [3:0] ex;
        string tg;
        ex = exp_q.pop_front();
        tg = tag_q.pop_front();
        compare(ex, tg);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; en = 1'b0; in1 = 1'b0; in2 = 1'b0; chop = 1'b0;
    repeat (3) @(posedge clk);
    #1 compare(4'b0000, "R5 reset state");
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(posedge clk);

    drv (0, 1, 0, 0, 4'b0000, "R1 disabled with forward inputs");
    drvn(3, 1, 1, 0, 0, 4'b1001, "R2 forward, no wait after reset (R6)");
    // chop: leg 2 low side released, high side after dead time
    drvn(DEAD, 1, 1, 0, 1, 4'b1000, "R7 chop releases low side");
    drvn(2, 1, 1, 0, 1, 4'b1010, "R7 synchronous rectification");
    // chop end
    drvn(DEAD, 1, 1, 0, 0, 4'b1000, "R8 chop end dead time");
    drv (1, 1, 0, 0, 4'b1001, "R8 low side back");
    // direction change
    drvn(DEAD, 1, 0, 1, 0, 4'b0000, "R6 reverse dead time");
    drvn(2, 1, 0, 1, 0, 4'b0110, "R2 reverse");
    // lower-path brake
    drvn(DEAD, 1, 0, 0, 0, 4'b0100, "R6 leg 2 dead time");
    drv (1, 0, 0, 0, 4'b0101, "R3 lower brake");
    // chop in lower brake lifts both legs
    drvn(DEAD, 1, 0, 0, 1, 4'b0000, "R7 chop in lower brake");
    drv (1, 0, 0, 1, 4'b1010, "R7 both legs rectify");
    drvn(DEAD, 1, 0, 0, 0, 4'b0000, "R8 both legs dead time");
    drv (1, 0, 0, 0, 4'b0101, "R8 lower brake restored");
    // upper-path brake
    drvn(DEAD, 1, 1, 1, 0, 4'b0000, "R6 upper brake dead time");
    drv (1, 1, 1, 0, 4'b1010, "R4 upper brake");
    drvn(3, 1, 1, 1, 1, 4'b1010, "R4 chop has no effect in upper brake");
    drv (1, 1, 1, 0, 4'b1010, "R4 upper brake after chop");
    // short disable then re-enable: dead time still counted from turn-off
    drv (0, 1, 1, 0, 4'b0000, "R1 disable");
    drvn(DEAD-1, 1, 1, 0, 0, 4'b0000, "R9 re-enable waits");
    drv (1, 1, 0, 0, 4'b1001, "R9 forward after wait");
    // bounce: reverse for one cycle, then back to forward
    drv (1, 0, 1, 0, 4'b0000, "R6 reverse starts");
    drvn(DEAD-1, 1, 1, 0, 0, 4'b0000, "R9 bounce back waits");
    drv (1, 1, 0, 0, 4'b1001, "R9 forward restored");
    // long disable: next turn-on is immediate
    drvn(DEAD+2, 0, 0, 1, 0, 4'b0000, "R1 long disable");
    drv (1, 0, 1, 0, 4'b0110, "R6 no wait after long off");

    repeat (3) @(posedge clk);
    #2;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule